// File: doc/BRIEF.md
# ECC Fault Status Flag Register

This block keeps the fault status of a nonvolatile memory array whose reads pass through an error-correcting decoder. Every completed array read is classified as clean, a corrected single-bit fault, an uncorrectable double-bit fault, or an access collision. A collision is a read issued while a memory command is still running, and it returns invalid data. The outcome is recorded in two sticky flags, one for single faults and one for double faults, inside an 8-bit status byte. Each flag drives its own level interrupt request, gated by an enable bit.

The recording path has one cycle of latency. The outcome is first captured in a pending stage and reaches the flags one clock later, so a status read made in the cycle right after the array read still shows the old value. Software clears a flag by writing 1 to its bit. A configuration input can stop corrected single-bit faults from being recorded. A collision is reported by raising both flags together, which cannot happen for a genuine fault.

Top module: `eccFaultStatus`

## Requirements
- R1: After reset both flags are 0, the status byte reads 0x00 and both interrupt requests are low.
- R2: A read (rdValid high, cmdBusy low) with sglFault high and dblFault low sets the single flag at bit 0. A read with dblFault high sets the double flag at bit 1. If both strobes are high, only the double flag is set. A genuine read never sets both flags.
- R3: A read while cmdBusy is high sets both flags, whatever the fault strobes and ignoreSgl are.
- R4: When ignoreSgl is high in the cycle of a genuine read, a single-bit fault does not set the single flag. Double faults are still recorded.
- R5: A register write with 1 in bit 0 or bit 1 clears that flag. A 0 in that bit leaves the flag unchanged. The two bits act independently.
- R6: A read sampled at clock edge k changes the status byte only after edge k+1. Between edge k and edge k+1 the byte still holds its earlier value.
- R7: If a recorded fault and a write-1 clear reach the same flag at the same edge, the flag ends at 1.
- R8: sglIrq equals the single flag AND sglIntEn, and dblIrq equals the double flag AND dblIntEn. Both are level signals.
- R9: Bits 7 to 2 of the status byte always read 0, and writes to them have no effect.
- R10: The fault strobes and cmdBusy have no effect while rdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdValid | input | 1 | An array read completes in this cycle |
| sglFault | input | 1 | Decoder found and corrected a single-bit error |
| dblFault | input | 1 | Decoder found an uncorrectable double-bit error |
| cmdBusy | input | 1 | A memory command is running |
| ignoreSgl | input | 1 | Do not record corrected single-bit faults |
| regWrEn | input | 1 | Write strobe for the status byte |
| regWrData | input | 8 | Write data; 1 clears the flag at that position |
| regRdData | output | 8 | Status byte: bit 0 single flag, bit 1 double flag |
| sglIntEn | input | 1 | Single-fault interrupt enable |
| dblIntEn | input | 1 | Double-fault interrupt enable |
| sglIrq | output | 1 | Single-fault interrupt request |
| dblIrq | output | 1 | Double-fault interrupt request |

## Verification
The embedded assertions check on every cycle the properties that hold between neighbouring cycles. A genuine read never stages both set strobes. A collision always stages both. An ignored single fault stages no set. A staged set always lands, a bare clear always drops the flag, and a flag without a strobe holds its value. A rising flag always traces back to a read two edges earlier. Only the bench scenarios can show the end-to-end outcomes seen at the ports: the exact bit positions in the status byte, the old value still visible in the cycle after a read, set winning over a clear at the same edge, writes to the unused bits, and the interrupt gating under each enable.

// File: rtl/eccStatPkg.sv
package eccStatPkg;

  // Strobes from the control stage to the flag datapath for one edge.
  typedef struct packed {
    logic setSgl;
    logic setDbl;
    logic clrSgl;
    logic clrDbl;
  } flagStrb_t;

  localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/eccStatCtrl.sv
module eccStatCtrl
  import eccStatPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SGL_POS = 0,
  parameter int DBL_POS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic              sglFault,
  input  logic              dblFault,
  input  logic              cmdBusy,
  input  logic              ignoreSgl,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output flagStrb_t         strb
);

  logic collide, genuine;
  logic evSgl, evDbl;
  logic pendSgl, pendDbl;
  logic unusedWrBits;

  assign collide = rdValid & cmdBusy;
  assign genuine = rdValid & ~cmdBusy;

  // Classify the read. The double fault has priority, and a collision marks both.
  assign evDbl = collide | (genuine & dblFault);
  assign evSgl = collide | (genuine & sglFault & ~dblFault & ~ignoreSgl);

  // One-cycle pending stage: the result reaches the flags one edge later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSgl <= 1'b0;
      pendDbl <= 1'b0;
    end else begin
      pendSgl <= evSgl;
      pendDbl <= evDbl;
    end
  end

  always_comb begin
    strb.setSgl = pendSgl;
    strb.setDbl = pendDbl;
    strb.clrSgl = regWrEn & regWrData[SGL_POS];
    strb.clrDbl = regWrEn & regWrData[DBL_POS];
  end

  assign unusedWrBits = ^regWrData;

  // R2
  genuine_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !cmdBusy) |=> !(strb.setSgl && strb.setDbl));

  // R3
  collide_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && cmdBusy) |=> (strb.setSgl && strb.setDbl));

  // R4
  ignore_sgl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !cmdBusy && ignoreSgl) |=> !strb.setSgl);

  // R10
  no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !(strb.setSgl || strb.setDbl));

endmodule

// File: rtl/eccStatFlags.sv
module eccStatFlags
  import eccStatPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SGL_POS = 0,
  parameter int DBL_POS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrb_t         strb,
  input  logic              sglIntEn,
  input  logic              dblIntEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              sglIrq,
  output logic              dblIrq
);

  logic [NUM_FLAGS-1:0] setV, clrV, enV, flagQ;

  assign setV = {strb.setDbl, strb.setSgl};
  assign clrV = {strb.clrDbl, strb.clrSgl};
  assign enV  = {dblIntEn, sglIntEn};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    // A set overrides a clear at the same edge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        flagQ[g] <= 1'b0;
      else if (setV[g]) flagQ[g] <= 1'b1;
      else if (clrV[g]) flagQ[g] <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      setV[g] |=> flagQ[g]);

    // R5
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrV[g] && !setV[g]) |=> !flagQ[g]);

    // R5
    hold_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!clrV[g] && !setV[g]) |=> $stable(flagQ[g]));
  end

  always_comb begin
    regRdData          = '0;
    regRdData[SGL_POS] = flagQ[0];
    regRdData[DBL_POS] = flagQ[1];
  end

  assign sglIrq = flagQ[0] & enV[0];
  assign dblIrq = flagQ[1] & enV[1];

endmodule

// File: rtl/eccFaultStatus.sv
module eccFaultStatus
  import eccStatPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SGL_POS = 0,
  parameter int DBL_POS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic              sglFault,
  input  logic              dblFault,
  input  logic              cmdBusy,
  input  logic              ignoreSgl,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sglIntEn,
  input  logic              dblIntEn,
  output logic              sglIrq,
  output logic              dblIrq
);

  flagStrb_t strb;

  eccStatCtrl #(.DATA_W(DATA_W), .SGL_POS(SGL_POS), .DBL_POS(DBL_POS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdValid   (rdValid),
    .sglFault  (sglFault),
    .dblFault  (dblFault),
    .cmdBusy   (cmdBusy),
    .ignoreSgl (ignoreSgl),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strb      (strb)
  );

  eccStatFlags #(.DATA_W(DATA_W), .SGL_POS(SGL_POS), .DBL_POS(DBL_POS)) uFlags (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sglIntEn  (sglIntEn),
    .dblIntEn  (dblIntEn),
    .regRdData (regRdData),
    .sglIrq    (sglIrq),
    .dblIrq    (dblIrq)
  );

  // R6
  rise_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(regRdData[SGL_POS]) || $rose(regRdData[DBL_POS])) |-> $past(rdValid, 2));

endmodule

// File: tb/tb_eccFaultStatus.sv
module tb_eccFaultStatus;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdValid = 0, sglFault = 0, dblFault = 0, cmdBusy = 0, ignoreSgl = 0;
  logic       regWrEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sglIntEn = 0, dblIntEn = 0;
  logic       sglIrq, dblIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eccFaultStatus dut (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .sglFault(sglFault),
    .dblFault(dblFault), .cmdBusy(cmdBusy), .ignoreSgl(ignoreSgl),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .sglIntEn(sglIntEn), .dblIntEn(dblIntEn), .sglIrq(sglIrq), .dblIrq(dblIrq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Drive one array read for a single edge; inputs change on the falling edge.
  task automatic pulseRead(input logic s, input logic d, input logic busy, input logic ign);
    @(negedge clk);
    rdValid = 1; sglFault = s; dblFault = d; cmdBusy = busy; ignoreSgl = ign;
    @(posedge clk);
    @(negedge clk);
    rdValid = 0; sglFault = 0; dblFault = 0; cmdBusy = 0; ignoreSgl = 0;
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1; regWrData = v;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 status", regRdData, 8'h00);
    chk("R1 irqs", {6'd0, dblIrq, sglIrq}, 8'h00);
  endtask

  task automatic testSingle();
    pulseRead(1, 0, 0, 0);
    chk("R6 not yet visible", regRdData, 8'h00);
    settle();
    chk("R2 single sets bit0", regRdData, 8'h01);
    writeReg(8'h01);
    chk("R5 clear single", regRdData, 8'h00);
  endtask

  task automatic testDouble();
    pulseRead(0, 1, 0, 0);
    settle();
    chk("R2 double sets bit1", regRdData, 8'h02);
    writeReg(8'h02);
    pulseRead(1, 1, 0, 0);
    settle();
    chk("R2 both strobes -> double only", regRdData, 8'h02);
    writeReg(8'h02);
    chk("R5 clear double", regRdData, 8'h00);
  endtask

  task automatic testCollision();
    pulseRead(0, 0, 1, 1);
    settle();
    chk("R3 collision sets both", regRdData, 8'h03);
    writeReg(8'h00);
    chk("R5 write zero keeps flags", regRdData, 8'h03);
    writeReg(8'h01);
    chk("R5 clear bit0 only", regRdData, 8'h02);
    writeReg(8'h02);
    chk("R5 clear bit1", regRdData, 8'h00);
  endtask

  task automatic testIgnore();
    pulseRead(1, 0, 0, 1);
    settle();
    chk("R4 ignored single", regRdData, 8'h00);
    pulseRead(0, 1, 0, 1);
    settle();
    chk("R4 double still recorded", regRdData, 8'h02);
    writeReg(8'h02);
  endtask

  task automatic testNoRead();
    @(negedge clk);
    sglFault = 1; dblFault = 1; cmdBusy = 1;
    settle(); settle();
    sglFault = 0; dblFault = 0; cmdBusy = 0;
    settle();
    chk("R10 strobes without read", regRdData, 8'h00);
  endtask

  task automatic testSetWins();
    pulseRead(0, 0, 1, 0);        // edge k sampled; now between k and k+1
    chk("R6 collision not yet visible", regRdData, 8'h00);
    regWrEn = 1; regWrData = 8'h03;   // clear meets the set at edge k+1
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
    chk("R7 set wins over clear", regRdData, 8'h03);
  endtask

  task automatic testIrq();
    // Flags are both 1 from the previous scenario.
    chk("R8 irqs masked", {6'd0, dblIrq, sglIrq}, 8'h00);
    sglIntEn = 1; #1;
    chk("R8 single irq", {6'd0, dblIrq, sglIrq}, 8'h01);
    sglIntEn = 0; dblIntEn = 1; #1;
    chk("R8 double irq", {6'd0, dblIrq, sglIrq}, 8'h02);
    writeReg(8'h02);
    chk("R8 double irq drops", {6'd0, dblIrq, sglIrq}, 8'h00);
    dblIntEn = 0;
    writeReg(8'h01);
  endtask

  task automatic testUnused();
    writeReg(8'hFC);
    chk("R9 upper bits read 0", regRdData, 8'h00);
    pulseRead(1, 0, 0, 0);
    settle();
    writeReg(8'hFC);
    chk("R9 upper write leaves flag", regRdData, 8'h01);
    writeReg(8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    testReset();
    rstN = 1;
    settle();
    testReset();
    testSingle();
    testDouble();
    testCollision();
    testIgnore();
    testNoRead();
    testSetWins();
    testIrq();
    testUnused();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule